// File: doc/BRIEF.md
# Wake Event Status and Enable Aggregator

This block collects the wake and power-management event sources of a platform into one 32-bit status register and one 32-bit enable register. Each source sets its own sticky status bit when its set condition holds. Software reads the bit and clears it by writing 1 to that position. A status bit that is also enabled raises a single system control interrupt request, which is registered.

The sources are as follows. An audio-codec wake sets its bit only when four conditions hold together. Two USB controller wake requests and a hot-plug event are captured on their rising edges. A software event control level holds its status bit set while the level is high. A thermal pin has selectable polarity. The block carries two reset domains. The resume-well reset clears all status bits and most enable bits. The always-on RTC reset clears the enable bits at positions 8, 10, 11 and 13, and resume-well resets leave those bits alone. A software-initiated hard reset, a power-button override and a processor thermal trip each clear a defined subset of the state.

Top module: `pme_event_hub`

## Requirements
- R1: With both resets asserted and then released, status reads 0, enable reads 0 and `sci_req` is 0.
- R2: Writing 1 to an implemented status bit (`reg_sel`=0) clears it. A status write of 0 leaves every bit unchanged.
- R3: Status bit 5 (audio wake) sets only when `aud_pmee`, `aud_clk_stopped`, `aud_route_en` and `aud_sdin` are all 1. Any other combination leaves it clear.
- R4: A `hard_rst` pulse clears every status bit except bit 5, which keeps its value. It also clears the resume-domain enable bits and leaves the RTC-domain enable bits (mask 0x00002D00) unchanged.
- R5: A rising edge of `usb_wake[0]` sets status bit 3, and a rising edge of `usb_wake[1]` sets status bit 4. A level held high does not set the bit again after a clear.
- R6: Status bit 2 follows `sw_evt_ctl` as a level. While the control is 1, the bit stays 1 even after a write-1 clear.
- R7: A rising edge of `hotplug_evt` sets status bit 1.
- R8: Status bit 0 sets whenever `thrm_pin` equals `thrm_pol`, so `thrm_pol`=1 makes the pin active high and `thrm_pol`=0 makes it active low.
- R9: Enable (`reg_sel`=1) is fully read/write over all 32 bits. Status bits 6 to 31 read 0 and ignore writes.
- R10: A resume-well reset clears the status bits and the enable bits outside mask 0x00002D00. Only `rst_rtc_n` clears the enable bits inside that mask.
- R11: A cycle with `pwrbtn_ovr` or `cpu_thermtrip` high clears all 32 enable bits, and this takes priority over an enable write in the same cycle.
- R12: `sci_req` goes high one cycle after any bit is set in both status and enable. It goes low one cycle after no such bit remains.
- R13: A hardware set of a status bit wins over a write-1 clear to the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_resume_n | input | 1 | Resume-well reset, active low, synchronous |
| rst_rtc_n | input | 1 | RTC-well reset, active low, synchronous |
| hard_rst | input | 1 | Software-initiated hard reset pulse |
| pwrbtn_ovr | input | 1 | Power-button override event, clears enables |
| cpu_thermtrip | input | 1 | Processor thermal trip event, clears enables |
| reg_sel | input | 1 | Register select: 0 status, 1 enable |
| reg_wr_en | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| aud_pmee | input | 1 | Audio function wake-enable qualifier |
| aud_clk_stopped | input | 1 | Audio link bit clock is stopped |
| aud_route_en | input | 1 | Audio serial input routing enabled |
| aud_sdin | input | 1 | Routed audio serial data input |
| usb_wake | input | 2 | USB controller wake requests |
| sw_evt_ctl | input | 1 | Software event control level |
| hotplug_evt | input | 1 | Hot-plug event |
| thrm_pin | input | 1 | Thermal pin |
| thrm_pol | input | 1 | Thermal polarity: 1 active high, 0 active low |
| sci_req | output | 1 | Registered system control interrupt request |

## Verification
The audio qualifier is swept over all sixteen combinations, which shows that the bit is an AND of all four conditions and not a partial product. The thermal pin is tried under both polarities at both levels, which separates a polarity-correct design from one that inverts or ignores the polarity bit. The interrupt request is checked with a single held status bit while one enable bit walks across all 32 positions, which exposes any enable that is miswired or unmasked. The reset-domain sequences (hard reset, resume reset, RTC reset, override and trip) each load all ones into the enables first. The surviving value therefore shows exactly which mask each event clears.

// File: rtl/pme_pkg.sv
package pme_pkg;
  localparam int unsigned REG_W = 32;

  localparam int unsigned BIT_THRM  = 0;
  localparam int unsigned BIT_HPLUG = 1;
  localparam int unsigned BIT_SWEVT = 2;
  localparam int unsigned BIT_USB0  = 3;
  localparam int unsigned BIT_USB1  = 4;
  localparam int unsigned BIT_AUDIO = 5;

  localparam int unsigned NUM_EDGE = 3;

  localparam logic [REG_W-1:0] STS_IMPL_MASK = 32'h0000_003F;
  localparam logic [REG_W-1:0] STS_KEEP_MASK = 32'h0000_0020;
  localparam logic [REG_W-1:0] EN_RTC_MASK   = 32'h0000_2D00;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/pme_edge_det.sv
module pme_edge_det #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= din[i];
    end
    assign rise[i] = din[i] & ~prev_q;
  end
endmodule

// File: rtl/pme_sts_reg.sv
module pme_sts_reg #(
  parameter int unsigned W    = 32,
  parameter logic [W-1:0] IMPL = '1,
  parameter logic [W-1:0] KEEP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hard_rst,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] sts_q
);
  logic [W-1:0] sts_d;

  always_comb begin
    sts_d = ((sts_q & ~clr_vec) | set_vec) & IMPL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        sts_q <= '0;
    else if (hard_rst) sts_q <= sts_q & KEEP;
    else               sts_q <= sts_d;
  end
endmodule

// File: rtl/pme_en_reg.sv
module pme_en_reg #(
  parameter int unsigned W        = 32,
  parameter logic [W-1:0] RTC_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_resume_n,
  input  logic         rst_rtc_n,
  input  logic         hard_rst,
  input  logic         wipe,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    if (RTC_MASK[i]) begin : g_rtc
      always_ff @(posedge clk) begin
        if (!rst_rtc_n) bit_q <= 1'b0;
        else if (wipe)  bit_q <= 1'b0;
        else if (we)    bit_q <= wdata[i];
      end
    end else begin : g_resume
      always_ff @(posedge clk) begin
        if (!rst_resume_n || hard_rst || wipe) bit_q <= 1'b0;
        else if (we)                           bit_q <= wdata[i];
      end
    end
    assign en_q[i] = bit_q;
  end
endmodule

// File: rtl/pme_event_hub.sv
module pme_event_hub
  import pme_pkg::*;
(
  input  logic             clk,
  input  logic             rst_resume_n,
  input  logic             rst_rtc_n,
  input  logic             hard_rst,
  input  logic             pwrbtn_ovr,
  input  logic             cpu_thermtrip,
  input  logic             reg_sel,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             aud_pmee,
  input  logic             aud_clk_stopped,
  input  logic             aud_route_en,
  input  logic             aud_sdin,
  input  logic [1:0]       usb_wake,
  input  logic             sw_evt_ctl,
  input  logic             hotplug_evt,
  input  logic             thrm_pin,
  input  logic             thrm_pol,
  output logic             sci_req
);
  logic [NUM_EDGE-1:0] edge_in, edge_rise;
  logic [REG_W-1:0]    set_vec, clr_vec, sts_q, en_q;
  logic                sts_we, en_we, wipe, thrm_active, aud_wake, sci_q;

  assign edge_in = {hotplug_evt, usb_wake[1], usb_wake[0]};

  pme_edge_det #(.N(NUM_EDGE)) u_edge (
    .clk   (clk),
    .rst_n (rst_resume_n),
    .din   (edge_in),
    .rise  (edge_rise)
  );

  assign thrm_active = ~(thrm_pin ^ thrm_pol);
  assign aud_wake    = aud_pmee & aud_clk_stopped & aud_route_en & aud_sdin;

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_THRM]  = thrm_active;
    set_vec[BIT_HPLUG] = edge_rise[2];
    set_vec[BIT_SWEVT] = sw_evt_ctl;
    set_vec[BIT_USB0]  = edge_rise[0];
    set_vec[BIT_USB1]  = edge_rise[1];
    set_vec[BIT_AUDIO] = aud_wake;
  end

  assign sts_we  = reg_wr_en && (reg_sel_e'(reg_sel) == SEL_STATUS);
  assign en_we   = reg_wr_en && (reg_sel_e'(reg_sel) == SEL_ENABLE);
  assign clr_vec = sts_we ? reg_wdata : '0;
  assign wipe    = pwrbtn_ovr | cpu_thermtrip;

  pme_sts_reg #(.W(REG_W), .IMPL(STS_IMPL_MASK), .KEEP(STS_KEEP_MASK)) u_sts (
    .clk      (clk),
    .rst_n    (rst_resume_n),
    .hard_rst (hard_rst),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .sts_q    (sts_q)
  );

  pme_en_reg #(.W(REG_W), .RTC_MASK(EN_RTC_MASK)) u_en (
    .clk          (clk),
    .rst_resume_n (rst_resume_n),
    .rst_rtc_n    (rst_rtc_n),
    .hard_rst     (hard_rst),
    .wipe         (wipe),
    .we           (en_we),
    .wdata        (reg_wdata),
    .en_q         (en_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_resume_n) sci_q <= 1'b0;
    else               sci_q <= |(sts_q & en_q);
  end

  assign sci_req   = sci_q;
  assign reg_rdata = (reg_sel_e'(reg_sel) == SEL_ENABLE) ? en_q : sts_q;
endmodule

// File: rtl/pme_event_hub_chk.sv
module pme_event_hub_chk (
  input logic        clk,
  input logic        rst_resume_n,
  input logic        rst_rtc_n,
  input logic        hard_rst,
  input logic        pwrbtn_ovr,
  input logic        cpu_thermtrip,
  input logic [31:0] sts,
  input logic [31:0] en,
  input logic        sci_req,
  input logic        thrm_pin,
  input logic        thrm_pol,
  input logic        sw_evt_ctl,
  input logic        aud_pmee,
  input logic        aud_clk_stopped,
  input logic        aud_route_en,
  input logic        aud_sdin
);
  logic rst_any;
  logic aud_ok;
  assign rst_any = !rst_resume_n || !rst_rtc_n;
  assign aud_ok  = aud_pmee && aud_clk_stopped && aud_route_en && aud_sdin;

  AST_SCI_RISE: assert property (@(posedge clk) disable iff (rst_any)
    (|(sts & en)) |=> sci_req); // R12
  AST_SCI_FALL: assert property (@(posedge clk) disable iff (rst_any)
    !(|(sts & en)) |=> !sci_req); // R12
  AST_AUDIO_GATED: assert property (@(posedge clk) disable iff (rst_any)
    (!sts[5] && !aud_ok) |=> !sts[5]); // R3
  AST_HARD_KEEPS_AUDIO: assert property (@(posedge clk) disable iff (rst_any)
    hard_rst |=> (sts[5] == $past(sts[5]))); // R4
  AST_SWEVT_HOLDS: assert property (@(posedge clk) disable iff (rst_any)
    (sw_evt_ctl && !hard_rst) |=> sts[2]); // R6
  AST_THRM_SET_WINS: assert property (@(posedge clk) disable iff (rst_any)
    ((thrm_pin == thrm_pol) && !hard_rst) |=> sts[0]); // R13
  AST_WIPE_ENABLES: assert property (@(posedge clk) disable iff (rst_any)
    (pwrbtn_ovr || cpu_thermtrip) |=> (en == 32'h0)); // R11
endmodule

bind pme_event_hub pme_event_hub_chk u_chk (
  .clk             (clk),
  .rst_resume_n    (rst_resume_n),
  .rst_rtc_n       (rst_rtc_n),
  .hard_rst        (hard_rst),
  .pwrbtn_ovr      (pwrbtn_ovr),
  .cpu_thermtrip   (cpu_thermtrip),
  .sts             (sts_q),
  .en              (en_q),
  .sci_req         (sci_req),
  .thrm_pin        (thrm_pin),
  .thrm_pol        (thrm_pol),
  .sw_evt_ctl      (sw_evt_ctl),
  .aud_pmee        (aud_pmee),
  .aud_clk_stopped (aud_clk_stopped),
  .aud_route_en    (aud_route_en),
  .aud_sdin        (aud_sdin)
);

// File: tb/tb_pme_event_hub.sv
`timescale 1ns/1ps
module tb_pme_event_hub;
  logic        clk = 1'b0;
  logic        rst_resume_n, rst_rtc_n, hard_rst, pwrbtn_ovr, cpu_thermtrip;
  logic        reg_sel, reg_wr_en;
  logic [31:0] reg_wdata, reg_rdata;
  logic        aud_pmee, aud_clk_stopped, aud_route_en, aud_sdin;
  logic [1:0]  usb_wake;
  logic        sw_evt_ctl, hotplug_evt, thrm_pin, thrm_pol, sci_req;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  pme_event_hub dut (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
    tick();
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    reg_sel = sel;
    #0.1;
    d = reg_rdata;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_resume_n = 0; rst_rtc_n = 0; hard_rst = 0; pwrbtn_ovr = 0; cpu_thermtrip = 0;
    reg_sel = 0; reg_wr_en = 0; reg_wdata = '0;
    aud_pmee = 0; aud_clk_stopped = 0; aud_route_en = 0; aud_sdin = 0;
    usb_wake = '0; sw_evt_ctl = 0; hotplug_evt = 0; thrm_pin = 0; thrm_pol = 1;
    repeat (3) tick();
    rst_resume_n = 1; rst_rtc_n = 1;
    tick();
    // R1 reset state
    rd(0, v); check("R1 status", v, 0);
    rd(1, v); check("R1 enable", v, 0);
    check("R1 sci", {31'b0, sci_req}, 0);

    // R9 enable fully RW, status reserved bits
    wr(1, 32'hFFFF_FFFF); rd(1, v); check("R9 enable ones", v, 32'hFFFF_FFFF);
    wr(1, 32'hA5A5_5A5A); rd(1, v); check("R9 enable pattern", v, 32'hA5A5_5A5A);
    wr(1, 32'h0);         rd(1, v); check("R9 enable zero", v, 0);
    wr(0, 32'hFFFF_FFC0); rd(0, v); check("R9 status reserved", v, 0);

    // R3 audio qualifier sweep
    for (int c = 0; c < 16; c++) begin
      {aud_pmee, aud_clk_stopped, aud_route_en, aud_sdin} = c[3:0];
      tick();
      {aud_pmee, aud_clk_stopped, aud_route_en, aud_sdin} = 4'b0;
      rd(0, v); check("R3 audio sweep", v, (c == 15) ? 32'h20 : 32'h0);
      wr(0, 32'h20); rd(0, v); check("R2 audio clear", v, 0);
    end

    // R8 thermal polarity
    for (int p = 0; p < 2; p++) begin
      for (int q = 0; q < 2; q++) begin
        thrm_pol = p[0]; thrm_pin = q[0];
        tick();
        thrm_pin = ~p[0];
        rd(0, v); check("R8 thermal", v, (p == q) ? 32'h1 : 32'h0);
        wr(0, 32'h1); rd(0, v); check("R2 thermal clear", v, 0);
      end
    end
    thrm_pol = 1; thrm_pin = 0;

    // R6 software level
    sw_evt_ctl = 1; tick();
    rd(0, v); check("R6 swevt set", v, 32'h4);
    wr(0, 32'h4); rd(0, v); check("R6 swevt held", v, 32'h4);
    sw_evt_ctl = 0; tick();
    wr(0, 32'h4); rd(0, v); check("R6 swevt cleared", v, 0);

    // R5 USB edges
    for (int u = 0; u < 2; u++) begin
      usb_wake[u] = 1'b1; tick();
      rd(0, v); check("R5 usb set", v, 32'h8 << u);
      wr(0, 32'h8 << u); tick();
      rd(0, v); check("R5 usb level no reset", v, 0);
      usb_wake[u] = 1'b0; tick();
    end

    // R7 hot-plug edge, R2 write-0
    hotplug_evt = 1; tick(); hotplug_evt = 0;
    rd(0, v); check("R7 hotplug set", v, 32'h2);
    wr(0, 32'h0); rd(0, v); check("R2 write zero keeps", v, 32'h2);
    wr(0, 32'h2); rd(0, v); check("R2 hotplug clear", v, 0);

    // R12 walking enable with bit 2 held
    sw_evt_ctl = 1; tick();
    for (int j = 0; j < 32; j++) begin
      wr(1, 32'h1 << j); tick();
      check("R12 sci walk", {31'b0, sci_req}, (j == 2) ? 32'h1 : 32'h0);
    end
    wr(1, 32'h4); tick();
    sw_evt_ctl = 0; tick();
    wr(0, 32'h4); tick();
    check("R12 sci falls", {31'b0, sci_req}, 0);
    wr(1, 32'h0);

    // R13 set beats clear
    thrm_pin = 1; tick();
    wr(0, 32'h1); rd(0, v); check("R13 thermal set wins", v, 32'h1);
    thrm_pin = 0; wr(0, 32'h1);
    usb_wake[0] = 1; wr(0, 32'h8);
    rd(0, v); check("R13 usb edge wins", v, 32'h8);
    usb_wake[0] = 0; wr(0, 32'h8); rd(0, v); check("R13 cleanup", v, 0);

    // R4 hard reset
    {aud_pmee, aud_clk_stopped, aud_route_en, aud_sdin} = 4'hF; tick();
    {aud_pmee, aud_clk_stopped, aud_route_en, aud_sdin} = 4'h0;
    hotplug_evt = 1; tick(); hotplug_evt = 0;
    wr(1, 32'hFFFF_FFFF);
    hard_rst = 1; tick(); hard_rst = 0;
    rd(0, v); check("R4 status keeps audio", v, 32'h20);
    rd(1, v); check("R4 enable keeps rtc", v, 32'h2D00);

    // R10 resume reset then RTC reset
    wr(1, 32'hFFFF_FFFF);
    rst_resume_n = 0; tick(); rst_resume_n = 1; tick();
    rd(0, v); check("R10 status cleared", v, 0);
    rd(1, v); check("R10 rtc enables survive", v, 32'h2D00);
    rst_rtc_n = 0; tick(); rst_rtc_n = 1; tick();
    rd(1, v); check("R10 rtc reset clears", v, 0);

    // R11 override and trip
    wr(1, 32'hFFFF_FFFF);
    pwrbtn_ovr = 1; tick(); pwrbtn_ovr = 0;
    rd(1, v); check("R11 power button", v, 0);
    wr(1, 32'hFFFF_FFFF);
    cpu_thermtrip = 1; reg_sel = 1; reg_wdata = 32'h1234_5678; reg_wr_en = 1;
    tick(); cpu_thermtrip = 0; reg_wr_en = 0;
    rd(1, v); check("R11 trip beats write", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule